// File: doc/BRIEF.md
# Page Staging Buffer with Wrapping Offset

This block gathers a stream of data bytes into a small flip-flop staging page before any of them reach the storage array. A load strobe sets the starting address. The upper bits of that address choose the page, and the lower bits give the first offset inside it. Each accepted byte is placed at the current offset, and the offset then steps forward by one, wrapping inside the page. If a transfer carries more bytes than the page holds, the later bytes replace the earlier ones. A per-offset flag records which locations received data in the current transfer.

A commit strobe moves the flagged bytes into the array through a simple synchronous write port. The burst writes one byte per cycle, lowest offset first, and touches no location that was not flagged. While the burst runs, the busy output is high and new bytes and loads are refused. A write-protect input makes the block refuse a commit. An abort strobe throws away the staged transfer, or cuts off a burst that is running.

Top module: `page_stage_buf`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low and no offset is flagged.
- R2: With `busy_o` low, `load_i` latches page = `addr_i[ADDR_W-1:5]` and offset = `addr_i[4:0]`, and clears every flag. A `byte_vld_i` in the same cycle is dropped.
- R3: With `busy_o` low and neither `load_i` nor `abort_i` asserted, `byte_vld_i` stores `byte_i` at the current offset and flags that offset. The offset then increments by one and the page does not change.
- R4: The offset wraps from 31 to 0. A later byte at an already flagged offset replaces the earlier one, so 34 bytes produce 32 array writes.
- R5: No array write happens before a commit. When `commit_i` is accepted with N flagged offsets (N > 0), `busy_o` rises on the next edge and stays high for exactly N cycles. In each of those cycles `mem_we_o` is high with `mem_addr_o` = {page, offset} and the last byte stored there, visiting flagged offsets in ascending order.
- R6: Array locations of the page that were not flagged in this transfer receive no write.
- R7: While `wp_i` is high, `commit_i` is ignored: `busy_o` stays low, no write occurs, and the flags are kept for a later commit.
- R8: After a burst completes, all flags are clear, so a further commit writes nothing. The offset is not reset by a commit.
- R9: While `busy_o` is high, `byte_vld_i` and `load_i` have no effect on the offset, page or flags.
- R10: `abort_i` has top priority. It clears all flags and drops `busy_o` on the next edge, ending any burst in progress.
- R11: A commit with no flagged offset leaves `busy_o` low and writes nothing.
- R12: A `byte_vld_i` in the same cycle as `commit_i` is stored first and is included in that commit's burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Latch start address strobe |
| addr_i | input | ADDR_W | Start address (page and offset) |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| commit_i | input | 1 | Commit request |
| abort_i | input | 1 | Discard staged transfer / stop burst |
| wp_i | input | 1 | Write protect, blocks commit |
| busy_o | output | 1 | Burst in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
Two pairs of functions can land on the same edge: the intake of a byte and the commit request, and the latching of an address and a byte strobe. The bench drives `byte_vld_i` together with `commit_i`, and separately together with `load_i`, in one cycle. The first case passes only if the simultaneous byte shows up in the burst at the next offset. The second passes only if the byte is dropped and the following byte lands at the freshly loaded offset. Abort is also raised in the first burst cycle, and exactly one array write must be recorded.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int DEF_DATA_W     = 8;
    localparam int DEF_PAGE_BYTES = 32;
    localparam int DEF_ADDR_W     = 13;
endpackage

// File: rtl/pwb_pick.sv
module pwb_pick #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // lowest set bit wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                found_o = 1'b1;
                idx_o   = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] ent_d [DEPTH];
    logic [DW-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (we_i && waddr_i == AW'(g)) begin
                ent_d[g] = wdata_i;
            end
        end

        always_ff @(posedge clk) begin
            ent_q[g] <= ent_d[g];
        end
    end

    assign rdata_o = ent_q[raddr_i];
endmodule

// File: rtl/page_stage_buf.sv
module page_stage_buf
    import pwb_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int ADDR_W     = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              commit_i,
    input  logic              abort_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFS_W;

    typedef struct packed {
        logic [PG_W-1:0]       page;
        logic [OFS_W-1:0]      ofs;
        logic [PAGE_BYTES-1:0] mask;
        logic                  busy;
    } st_t;

    st_t s_d, s_q;

    logic             st_we;
    logic             pick_found;
    logic [OFS_W-1:0] pick_idx;
    logic [DATA_W-1:0] rd_byte;
    logic [PAGE_BYTES-1:0] mask_left;

    pwb_pick #(.N(PAGE_BYTES)) u_pick (
        .mask_i  (s_q.mask),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    pwb_store #(.DW(DATA_W), .DEPTH(PAGE_BYTES)) u_store (
        .clk     (clk),
        .we_i    (st_we),
        .waddr_i (s_q.ofs),
        .wdata_i (byte_i),
        .raddr_i (pick_idx),
        .rdata_o (rd_byte)
    );

    always_comb begin
        s_d       = s_q;
        st_we     = 1'b0;
        mask_left = s_q.mask;
        if (abort_i) begin
            s_d.mask = '0;
            s_d.busy = 1'b0;
        end else if (s_q.busy) begin
            if (pick_found) begin
                mask_left[pick_idx] = 1'b0;
            end
            s_d.mask = mask_left;
            s_d.busy = (mask_left != '0);
        end else begin
            if (load_i) begin
                s_d.page = addr_i[ADDR_W-1:OFS_W];
                s_d.ofs  = addr_i[OFS_W-1:0];
                s_d.mask = '0;
            end else if (byte_vld_i) begin
                st_we              = 1'b1;
                s_d.mask[s_q.ofs]  = 1'b1;
                s_d.ofs            = s_q.ofs + 1'b1;
            end
            if (commit_i && !wp_i && s_d.mask != '0) begin
                s_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o      = s_q.busy;
    assign mem_we_o    = s_q.busy && pick_found;
    assign mem_addr_o  = {s_q.page, pick_idx};
    assign mem_wdata_o = rd_byte;

    // R3
    ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && byte_vld_i && !load_i && !abort_i)
        |=> (s_q.ofs == OFS_W'($past(s_q.ofs) + 1'b1)) && (s_q.page == $past(s_q.page)));

    // R5
    burst_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !abort_i)
        |=> ($countones(s_q.mask) + 1) == $countones($past(s_q.mask)));

    // R7
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && wp_i) |=> !s_q.busy);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !abort_i)
        |=> (s_q.ofs == $past(s_q.ofs)) && (s_q.page == $past(s_q.page)));

    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (s_q.mask == '0) && !s_q.busy);

    // R11
    empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && commit_i && !byte_vld_i && s_q.mask == '0) |=> !s_q.busy);
endmodule

// File: tb/sim_page_stage_buf.sv
module sim_page_stage_buf;
    localparam int AW = 13;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          byte_vld_i = 1'b0;
    logic [DW-1:0] byte_i = '0;
    logic          commit_i = 1'b0;
    logic          abort_i = 1'b0;
    logic          wp_i = 1'b0;
    logic          busy_o;
    logic          mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int wlog [64];
    logic [DW-1:0] mem_m [int];
    bit done = 1'b0;

    always #4 clk = ~clk;

    page_stage_buf u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .addr_i(addr_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .commit_i(commit_i),
        .abort_i(abort_i), .wp_i(wp_i), .busy_o(busy_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    // synchronous memory model, observed away from the rising edge
    always @(negedge clk) begin
        if (rst_n && mem_we_o) begin
            mem_m[int'(mem_addr_o)] = mem_wdata_o;
            if (wr_cnt < 64) wlog[wr_cnt] = int'(mem_addr_o);
            wr_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_model();
        mem_m.delete();
        wr_cnt = 0;
    endtask

    task automatic do_load(input int a);
        @(negedge clk);
        load_i = 1'b1; addr_i = AW'(a);
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic do_byte(input int d);
        @(negedge clk);
        byte_vld_i = 1'b1; byte_i = DW'(d);
        @(negedge clk);
        byte_vld_i = 1'b0;
    endtask

    task automatic drain(output int bcyc);
        bcyc = 0;
        while (busy_o) begin
            bcyc++;
            @(negedge clk);
        end
    endtask

    task automatic do_commit(output int bcyc);
        @(negedge clk);
        commit_i = 1'b1;
        @(negedge clk);
        commit_i = 1'b0;
        drain(bcyc);
    endtask

    function automatic int rd(input int a);
        if (mem_m.exists(a)) return int'(mem_m[a]);
        return -1;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(!busy_o, "R1 busy", int'(busy_o), 0);
        chk(!mem_we_o, "R1 we", int'(mem_we_o), 0);
    endtask

    task automatic t_single();
        int b;
        clr_model();
        do_load(13'h0123);
        do_byte(8'h3C);
        chk(wr_cnt == 0, "R5 no write before commit", wr_cnt, 0);
        do_commit(b);
        chk(b == 1, "R5 busy cycles", b, 1);
        chk(rd(13'h0123) == 8'h3C, "R3 single data", rd(13'h0123), 8'h3C);
    endtask

    task automatic t_wrap();
        int b;
        clr_model();
        do_load(13'h0A1E);
        for (int i = 0; i < 4; i++) do_byte(8'h10 + i);
        do_commit(b);
        chk(b == 4, "R5 busy cycles", b, 4);
        chk(wr_cnt == 4, "R5 write count", wr_cnt, 4);
        chk(wlog[0] == 13'h0A00 && wlog[1] == 13'h0A01, "R4 ascending low", wlog[0], 13'h0A00);
        chk(wlog[2] == 13'h0A1E && wlog[3] == 13'h0A1F, "R5 ascending high", wlog[2], 13'h0A1E);
        chk(rd(13'h0A00) == 8'h12, "R4 wrapped byte", rd(13'h0A00), 8'h12);
        chk(rd(13'h0A20) == -1, "R3 page fixed", rd(13'h0A20), -1);
        chk(rd(13'h0A02) == -1, "R6 unflagged untouched", rd(13'h0A02), -1);
    endtask

    task automatic t_overrun();
        int b;
        clr_model();
        do_load(13'h1F60);
        for (int i = 0; i < 34; i++) do_byte(i + 1);
        do_commit(b);
        chk(wr_cnt == 32, "R4 write count", wr_cnt, 32);
        chk(b == 32, "R5 busy cycles", b, 32);
        chk(rd(13'h1F60) == 33, "R4 overwrite 0", rd(13'h1F60), 33);
        chk(rd(13'h1F61) == 34, "R4 overwrite 1", rd(13'h1F61), 34);
        chk(rd(13'h1F7F) == 32, "R4 last slot", rd(13'h1F7F), 32);
    endtask

    task automatic t_wp();
        int b;
        clr_model();
        do_load(13'h0200);
        do_byte(8'h5A);
        do_byte(8'h5B);
        wp_i = 1'b1;
        do_commit(b);
        chk(b == 0, "R7 busy under wp", b, 0);
        chk(wr_cnt == 0, "R7 no write under wp", wr_cnt, 0);
        wp_i = 1'b0;
        do_commit(b);
        chk(wr_cnt == 2, "R7 flags kept", wr_cnt, 2);
        chk(rd(13'h0201) == 8'h5B, "R7 data kept", rd(13'h0201), 8'h5B);
    endtask

    task automatic t_abort_idle();
        int b;
        clr_model();
        do_load(13'h0300);
        for (int i = 0; i < 3; i++) do_byte(8'h70 + i);
        @(negedge clk); abort_i = 1'b1;
        @(negedge clk); abort_i = 1'b0;
        do_commit(b);
        chk(wr_cnt == 0 && b == 0, "R10 abort clears", wr_cnt, 0);
    endtask

    task automatic t_empty();
        int b;
        clr_model();
        do_load(13'h0400);
        do_commit(b);
        chk(b == 0, "R11 empty busy", b, 0);
        chk(wr_cnt == 0, "R11 empty writes", wr_cnt, 0);
    endtask

    task automatic t_busy_ignore();
        int b;
        clr_model();
        do_load(13'h0500);
        for (int i = 0; i < 3; i++) do_byte(8'hA0 + i);
        @(negedge clk); commit_i = 1'b1;
        @(negedge clk); commit_i = 1'b0;
        byte_vld_i = 1'b1; byte_i = 8'hEE; load_i = 1'b1; addr_i = 13'h0777;
        @(negedge clk);
        byte_vld_i = 1'b0; load_i = 1'b0;
        drain(b);
        chk(wr_cnt == 3, "R9 writes", wr_cnt, 3);
        chk(rd(13'h0502) == 8'hA2, "R9 data", rd(13'h0502), 8'hA2);
        do_commit(b);
        chk(wr_cnt == 3, "R8 flags cleared", wr_cnt, 3);
        do_byte(8'h77);
        do_commit(b);
        chk(rd(13'h0503) == 8'h77, "R9 offset held", rd(13'h0503), 8'h77);
        chk(rd(13'h0777) == -1, "R9 load ignored", rd(13'h0777), -1);
    endtask

    task automatic t_same_cycle();
        int b;
        clr_model();
        do_load(13'h0600);
        do_byte(8'h11);
        @(negedge clk);
        byte_vld_i = 1'b1; byte_i = 8'h22; commit_i = 1'b1;
        @(negedge clk);
        byte_vld_i = 1'b0; commit_i = 1'b0;
        drain(b);
        chk(wr_cnt == 2, "R12 byte joins commit", wr_cnt, 2);
        chk(rd(13'h0601) == 8'h22, "R12 data", rd(13'h0601), 8'h22);
        clr_model();
        @(negedge clk);
        load_i = 1'b1; addr_i = 13'h0040; byte_vld_i = 1'b1; byte_i = 8'hAA;
        @(negedge clk);
        load_i = 1'b0; byte_vld_i = 1'b0;
        do_byte(8'hBB);
        do_commit(b);
        chk(wr_cnt == 1, "R2 byte dropped", wr_cnt, 1);
        chk(rd(13'h0040) == 8'hBB, "R2 load offset", rd(13'h0040), 8'hBB);
    endtask

    task automatic t_abort_busy();
        int b;
        clr_model();
        do_load(13'h0700);
        for (int i = 0; i < 5; i++) do_byte(8'hC0 + i);
        @(negedge clk); commit_i = 1'b1;
        @(negedge clk); commit_i = 1'b0; abort_i = 1'b1;
        @(negedge clk); abort_i = 1'b0;
        chk(!busy_o, "R10 busy drops", int'(busy_o), 0);
        drain(b);
        chk(wr_cnt == 1, "R10 burst cut", wr_cnt, 1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_wrap();
        t_overrun();
        t_wp();
        t_abort_idle();
        t_empty();
        t_busy_ignore();
        t_same_cycle();
        t_abort_busy();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule